// File: doc/BRIEF.md
# Pulse and Quadrature Counter

This block counts events derived from one or two asynchronous input lines, S0 and S1. A two-bit mode input chooses between an idle state, two single-input modes in which one edge of S0 is counted, and a quadrature mode in which the Gray-code sequence on the S1/S0 pair is decoded into forward and backward steps. Each detected step is reported as an up-event or a down-event strobe. A 16-bit main counter follows these strobes, gated by its own event selector. A 16-bit auxiliary counter only ever increments, and it can be fed from up events, down events, both or neither.

Both lines pass through a two-flop synchronizer. A four-state machine then holds the last sampled phase {S1,S0}: PH_00, PH_01, PH_11 and PH_10. On every clock the machine moves to the current phase, whatever the mode. The edge between its held phase and the current phase is what the decoders read. In quadrature mode the forward transitions PH_00→PH_01, PH_01→PH_11, PH_11→PH_10 and PH_10→PH_00 are up steps, and the reverse transitions are down steps. Staying in the same phase, or jumping to the diagonal phase (both bits changing), gives no event. A synchronous clear input zeroes the main counter. The auxiliary counter is zeroed with it only when its clear-enable input is set.

Top module: `pulse_quad_counter`

## Requirements
- R1: After reset both counts are 0, both strobes are 0, and the mode is taken from `mode_sel` (0 = off).
- R2: With `mode_sel` = 0 no up or down event is produced and both counts hold.
- R3: In modes 1 and 2, which behave the same here, each selected edge of S0 gives exactly one event. The selected edge is the rising edge when `edge_fall` = 0 and the falling edge when `edge_fall` = 1.
- R4: In the single-input modes the direction comes from `dir_down` (0 up, 1 down) when `dir_from_s1` = 0. When `dir_from_s1` = 1 the synchronized S1 level decides instead (1 down, 0 up).
- R5: In mode 3, the {S1,S0} sequence 00→01→11→10→00 gives one up event per step and the reverse gives one down event per step. A change of both bits at once gives none. `edge_fall`, `dir_down` and `dir_from_s1` have no effect in this mode. Up and down strobes are never high together.
- R6: `main_gate` selects which events move the main counter: 0 both (up +1, down −1), 1 up only, 2 down only, 3 none.
- R7: `aux_gate` selects which events increment the auxiliary counter: 0 none, 1 up, 2 down, 3 both. The auxiliary counter never decrements.
- R8: `cnt_clear` zeroes the main counter on the next edge, and this takes priority over counting. The auxiliary counter is zeroed too only when `aux_clear_en` = 1; otherwise it keeps counting.
- R9: The main counter wraps modulo 2^16 in both directions.
- R10: A change on S0/S1 shows on the counts and strobes after the third rising clock edge following it. A strobe lasts one cycle, in the same cycle as the count change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s0_in | input | 1 | Asynchronous count input S0 |
| s1_in | input | 1 | Asynchronous second input S1 (direction or quadrature phase) |
| mode_sel | input | 2 | 0 off, 1 oversampled single, 2 external-edge single, 3 quadrature |
| edge_fall | input | 1 | Single modes: 0 count rising edges, 1 falling edges |
| dir_down | input | 1 | Single modes: fixed direction, 1 = down |
| dir_from_s1 | input | 1 | Single modes: take direction from the S1 level |
| main_gate | input | 2 | Main counter event selector |
| aux_gate | input | 2 | Auxiliary counter event selector |
| cnt_clear | input | 1 | Synchronous counter clear |
| aux_clear_en | input | 1 | Let `cnt_clear` also zero the auxiliary counter |
| main_count | output | 16 | Main up/down count |
| aux_count | output | 16 | Auxiliary increment-only count |
| up_evt | output | 1 | One-cycle up-event strobe |
| down_evt | output | 1 | One-cycle down-event strobe |

## Verification
The properties assume that the configuration inputs are synchronous to `clk` and held steady around each clock edge. S0 and S1 may change at any time, because they are synchronized. The bench changes every input half a period away from the active edge. It holds each S0 level and each quadrature phase for at least two cycles, so that every intended transition reaches the phase register as a distinct step. The one deliberate diagonal jump is there to check that no event is produced. A behavioural model with its own three-deep input history predicts counts and strobes on every cycle.

// File: rtl/pqc_pkg.sv
package pqc_pkg;

    typedef enum logic [1:0] {
        MODE_OFF        = 2'd0,
        MODE_OVS_SINGLE = 2'd1,
        MODE_EXT_SINGLE = 2'd2,
        MODE_QUAD       = 2'd3
    } mode_e;

    // Phase code is {S1,S0}
    typedef enum logic [1:0] {
        PH_00 = 2'b00,
        PH_01 = 2'b01,
        PH_11 = 2'b11,
        PH_10 = 2'b10
    } phase_e;

    typedef enum logic [1:0] {
        MG_BOTH = 2'd0,
        MG_UP   = 2'd1,
        MG_DOWN = 2'd2,
        MG_NONE = 2'd3
    } main_gate_e;

    typedef struct packed {
        logic up;
        logic dn;
    } evt_t;

endpackage

// File: rtl/pqc_sync.sv
module pqc_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stg [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[0] <= '0;
                else        stg[0] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[i] <= '0;
                else        stg[i] <= stg[i-1];
            end
        end
    end

    assign dout = stg[STAGES-1];

endmodule

// File: rtl/pqc_event_decode.sv
module pqc_event_decode
    import pqc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  phase_now,
    input  mode_e       mode,
    input  logic        edge_fall,
    input  logic        dir_down,
    input  logic        dir_from_s1,
    output evt_t        evt
);

    phase_e state_q;
    phase_e ph_now;
    logic   q_up, q_dn;
    logic   s0_rise, s0_fall, edge_hit, go_down;

    assign ph_now = phase_e'(phase_now);

    // State register: always tracks the last sampled phase
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PH_00;
        else        state_q <= ph_now;
    end

    // Quadrature step decode from (held phase, current phase)
    always_comb begin
        q_up = 1'b0;
        q_dn = 1'b0;
        unique case (state_q)
            PH_00: begin q_up = (ph_now == PH_01); q_dn = (ph_now == PH_10); end
            PH_01: begin q_up = (ph_now == PH_11); q_dn = (ph_now == PH_00); end
            PH_11: begin q_up = (ph_now == PH_10); q_dn = (ph_now == PH_01); end
            PH_10: begin q_up = (ph_now == PH_00); q_dn = (ph_now == PH_11); end
            default: begin q_up = 1'b0; q_dn = 1'b0; end
        endcase
    end

    assign s0_rise  = phase_now[0] & ~state_q[0];
    assign s0_fall  = ~phase_now[0] & state_q[0];
    assign edge_hit = edge_fall ? s0_fall : s0_rise;
    assign go_down  = dir_from_s1 ? phase_now[1] : dir_down;

    // Output process: mode picks the event source
    always_comb begin
        evt = '0;
        unique case (mode)
            MODE_OFF: evt = '0;
            MODE_OVS_SINGLE, MODE_EXT_SINGLE: begin
                evt.up = edge_hit & ~go_down;
                evt.dn = edge_hit & go_down;
            end
            MODE_QUAD: begin
                evt.up = q_up;
                evt.dn = q_dn;
            end
            default: evt = '0;
        endcase
    end

endmodule

// File: rtl/pqc_counters.sv
module pqc_counters
    import pqc_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter bit AUX_PRESENT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  evt_t             evt,
    input  main_gate_e       main_gate,
    input  logic [1:0]       aux_gate,
    input  logic             clr,
    input  logic             aux_clr_en,
    output logic [CNT_W-1:0] main_q,
    output logic [CNT_W-1:0] aux_q,
    output logic             up_q,
    output logic             dn_q
);

    logic main_inc, main_dec, aux_inc;

    assign main_inc = evt.up & ((main_gate == MG_BOTH) | (main_gate == MG_UP));
    assign main_dec = evt.dn & ((main_gate == MG_BOTH) | (main_gate == MG_DOWN));
    assign aux_inc  = (evt.up & aux_gate[0]) | (evt.dn & aux_gate[1]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            main_q <= '0;
            up_q   <= 1'b0;
            dn_q   <= 1'b0;
        end else begin
            up_q <= evt.up;
            dn_q <= evt.dn;
            if (clr)           main_q <= '0;
            else if (main_inc) main_q <= main_q + 1'b1;
            else if (main_dec) main_q <= main_q - 1'b1;
        end
    end

    if (AUX_PRESENT) begin : g_aux
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                aux_q <= '0;
            else if (clr && aux_clr_en) aux_q <= '0;
            else if (aux_inc)          aux_q <= aux_q + 1'b1;
        end
    end else begin : g_no_aux
        assign aux_q = '0;
    end

endmodule

// File: rtl/pulse_quad_counter.sv
module pulse_quad_counter
    import pqc_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             s0_in,
    input  logic             s1_in,
    input  logic [1:0]       mode_sel,
    input  logic             edge_fall,
    input  logic             dir_down,
    input  logic             dir_from_s1,
    input  logic [1:0]       main_gate,
    input  logic [1:0]       aux_gate,
    input  logic             cnt_clear,
    input  logic             aux_clear_en,
    output logic [CNT_W-1:0] main_count,
    output logic [CNT_W-1:0] aux_count,
    output logic             up_evt,
    output logic             down_evt
);

    localparam int PH_W = 2;

    logic [PH_W-1:0] phase_sync;
    evt_t            evt;

    pqc_sync #(.WIDTH(PH_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({s1_in, s0_in}),
        .dout  (phase_sync)
    );

    pqc_event_decode u_decode (
        .clk         (clk),
        .rst_n       (rst_n),
        .phase_now   (phase_sync),
        .mode        (mode_e'(mode_sel)),
        .edge_fall   (edge_fall),
        .dir_down    (dir_down),
        .dir_from_s1 (dir_from_s1),
        .evt         (evt)
    );

    pqc_counters #(.CNT_W(CNT_W), .AUX_PRESENT(1'b1)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt        (evt),
        .main_gate  (main_gate_e'(main_gate)),
        .aux_gate   (aux_gate),
        .clr        (cnt_clear),
        .aux_clr_en (aux_clear_en),
        .main_q     (main_count),
        .aux_q      (aux_count),
        .up_q       (up_evt),
        .dn_q       (down_evt)
    );

endmodule

// File: rtl/pqc_checker.sv
module pqc_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       mode_sel,
    input logic [1:0]       main_gate,
    input logic             cnt_clear,
    input logic             aux_clear_en,
    input logic [CNT_W-1:0] main_count,
    input logic [CNT_W-1:0] aux_count,
    input logic             up_evt,
    input logic             down_evt
);

    p_evt_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(up_evt && down_evt));

    p_off_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'd0) |=> (!up_evt && !down_evt));

    p_clear_main_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clear |=> (main_count == '0));

    p_clear_aux_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_clear && aux_clear_en) |=> (aux_count == '0));

    p_aux_mono_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(cnt_clear && aux_clear_en) |=>
            ((aux_count == $past(aux_count)) ||
             (aux_count == CNT_W'($past(aux_count) + 1'b1))));

    p_main_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (main_gate == 2'd3 && !cnt_clear) |=> $stable(main_count));

endmodule

bind pulse_quad_counter pqc_checker #(.CNT_W(CNT_W)) u_pqc_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_sel     (mode_sel),
    .main_gate    (main_gate),
    .cnt_clear    (cnt_clear),
    .aux_clear_en (aux_clear_en),
    .main_count   (main_count),
    .aux_count    (aux_count),
    .up_evt       (up_evt),
    .down_evt     (down_evt)
);

// File: tb/pulse_quad_counter_bench.sv
`timescale 1ns/1ps
module pulse_quad_counter_bench;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        s0 = 1'b0, s1 = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic        edge_fall = 1'b0, dir_down = 1'b0, dir_from_s1 = 1'b0;
    logic [1:0]  mgate = 2'd0, agate = 2'd0;
    logic        clr = 1'b0, aclr_en = 1'b0;
    logic [15:0] main_count, aux_count;
    logic        up_evt, down_evt;

    pulse_quad_counter u_pulse_quad_counter (
        .clk(clk), .rst_n(rst_n), .s0_in(s0), .s1_in(s1), .mode_sel(mode),
        .edge_fall(edge_fall), .dir_down(dir_down), .dir_from_s1(dir_from_s1),
        .main_gate(mgate), .aux_gate(agate), .cnt_clear(clr),
        .aux_clear_en(aclr_en), .main_count(main_count), .aux_count(aux_count),
        .up_evt(up_evt), .down_evt(down_evt)
    );

    int    n_checks = 0;
    int    n_fail   = 0;
    string cur_req  = "R1";
    bit    done     = 1'b0;
    int    pi       = 0;

    // Reference model: input history, counts and strobes
    logic [1:0]  h1 = '0, h2 = '0, h3 = '0;
    logic [15:0] m_main = '0, m_aux = '0;
    logic        m_up = 1'b0, m_dn = 1'b0;

    function automatic int gidx(logic [1:0] p);
        case (p)
            2'b00: return 0;
            2'b01: return 1;
            2'b11: return 2;
            default: return 3;
        endcase
    endfunction

    function automatic logic [1:0] gcode(int i);
        case (i & 3)
            0: return 2'b00;
            1: return 2'b01;
            2: return 2'b11;
            default: return 2'b10;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            h1 = '0; h2 = '0; h3 = '0;
            m_main = '0; m_aux = '0; m_up = 1'b0; m_dn = 1'b0;
        end else begin
            logic u, d, e, dirdn;
            int   df;
            u = 1'b0; d = 1'b0;
            if (mode == 2'd1 || mode == 2'd2) begin
                e = edge_fall ? (h3[0] && !h2[0]) : (!h3[0] && h2[0]);
                dirdn = dir_from_s1 ? h2[1] : dir_down;
                u = e && !dirdn;
                d = e && dirdn;
            end else if (mode == 2'd3) begin
                df = (gidx(h2) - gidx(h3) + 4) % 4;
                u = (df == 1);
                d = (df == 3);
            end
            if (clr) m_main = '0;
            else if (u && (mgate == 2'd0 || mgate == 2'd1)) m_main = m_main + 16'd1;
            else if (d && (mgate == 2'd0 || mgate == 2'd2)) m_main = m_main - 16'd1;
            if (clr && aclr_en) m_aux = '0;
            else if ((u && agate[0]) || (d && agate[1])) m_aux = m_aux + 16'd1;
            m_up = u; m_dn = d;
            h3 = h2; h2 = h1; h1 = {s1, s0};
        end
    end

    // Cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            n_checks++;
            if (main_count !== m_main || aux_count !== m_aux ||
                up_evt !== m_up || down_evt !== m_dn) begin
                n_fail++;
                $display("FAIL %s model: main=%h aux=%h up=%b dn=%b expected main=%h aux=%h up=%b dn=%b",
                         cur_req, main_count, aux_count, up_evt, down_evt,
                         m_main, m_aux, m_up, m_dn);
            end
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp, string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic pulse(int n);
        repeat (n) begin
            s0 = 1'b1; tick(2);
            s0 = 1'b0; tick(2);
        end
        tick(4);
    endtask

    task automatic qstep(bit up, int n);
        repeat (n) begin
            pi = up ? pi + 1 : pi + 3;
            {s1, s0} = gcode(pi);
            tick(2);
        end
        tick(4);
    endtask

    task automatic do_clear();
        clr = 1'b1; tick(1);
        clr = 1'b0; tick(1);
    endtask

    initial begin
        #(8 * 50000);
        if (!done) begin
            done = 1'b1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1: reset state
        cur_req = "R1";
        chk("R1", main_count, 16'd0, "main after reset");
        chk("R1", aux_count, 16'd0, "aux after reset");
        chk("R1", {14'd0, up_evt, down_evt}, 16'd0, "strobes after reset");

        // R3: rising edges, fixed up
        cur_req = "R3"; mode = 2'd1; agate = 2'd3; tick(2);
        pulse(5);
        chk("R3", main_count, 16'd5, "five rising edges");
        chk("R7", aux_count, 16'd5, "aux both-gate");

        // R4: fixed down
        cur_req = "R4"; dir_down = 1'b1; tick(1);
        pulse(3);
        chk("R4", main_count, 16'd2, "fixed down");

        // R3: falling edges in mode 2
        cur_req = "R3"; dir_down = 1'b0; edge_fall = 1'b1; mode = 2'd2; tick(1);
        pulse(4);
        chk("R3", main_count, 16'd6, "falling edges");

        // R4: direction from S1
        cur_req = "R4"; dir_from_s1 = 1'b1; s1 = 1'b1; tick(4);
        pulse(2);
        chk("R4", main_count, 16'd4, "S1 high counts down");
        s1 = 1'b0; tick(4);
        pulse(1);
        chk("R4", main_count, 16'd5, "S1 low counts up");

        // R2: off mode
        cur_req = "R2"; mode = 2'd0; tick(1);
        pulse(3);
        chk("R2", main_count, 16'd5, "main holds when off");
        chk("R2", aux_count, 16'd15, "aux holds when off");

        // R8: clear with and without aux clear
        cur_req = "R8";
        do_clear();
        chk("R8", main_count, 16'd0, "main cleared");
        chk("R8", aux_count, 16'd15, "aux kept without enable");
        aclr_en = 1'b1;
        do_clear();
        chk("R8", aux_count, 16'd0, "aux cleared with enable");

        // R5: quadrature, single-input controls set to odd values
        cur_req = "R5"; edge_fall = 1'b1; dir_down = 1'b1; dir_from_s1 = 1'b0;
        pi = 0; mode = 2'd3; tick(4);
        qstep(1'b1, 8);
        chk("R5", main_count, 16'd8, "eight forward steps");
        qstep(1'b0, 3);
        chk("R5", main_count, 16'd5, "three reverse steps");
        pi = pi + 2; {s1, s0} = gcode(pi); tick(6);
        chk("R5", main_count, 16'd5, "diagonal jump ignored");
        qstep(1'b1, 1);
        chk("R5", main_count, 16'd6, "step after jump");

        // R6: main gating
        cur_req = "R6"; do_clear(); mgate = 2'd1;
        qstep(1'b1, 4); qstep(1'b0, 2);
        chk("R6", main_count, 16'd4, "up-only gate");
        do_clear(); mgate = 2'd2;
        qstep(1'b1, 3); qstep(1'b0, 2);
        chk("R6", main_count, 16'hFFFE, "down-only gate");
        do_clear(); mgate = 2'd3;
        qstep(1'b1, 3);
        chk("R6", main_count, 16'd0, "no-count gate");

        // R7: aux gating
        cur_req = "R7"; mgate = 2'd0; do_clear(); agate = 2'd2;
        qstep(1'b1, 3); qstep(1'b0, 2);
        chk("R7", aux_count, 16'd2, "aux down-only increments");
        agate = 2'd0;
        qstep(1'b1, 3); qstep(1'b0, 2);
        chk("R7", aux_count, 16'd2, "aux none");
        agate = 2'd1;
        qstep(1'b1, 3); qstep(1'b0, 2);
        chk("R7", aux_count, 16'd5, "aux up-only");

        // R9: wrap
        cur_req = "R9"; do_clear();
        qstep(1'b0, 2);
        chk("R9", main_count, 16'hFFFE, "wrap below zero");
        qstep(1'b1, 3);
        chk("R9", main_count, 16'd1, "wrap above max");

        // R10: latency
        cur_req = "R10"; mode = 2'd1; edge_fall = 1'b0; dir_down = 1'b0;
        s0 = 1'b0; s1 = 1'b0; tick(6); do_clear(); tick(2);
        s0 = 1'b1;
        tick(1);
        chk("R10", main_count, 16'd0, "after 1st edge");
        tick(1);
        chk("R10", {15'd0, up_evt}, 16'd0, "strobe after 2nd edge");
        tick(1);
        chk("R10", main_count, 16'd1, "after 3rd edge");
        chk("R10", {15'd0, up_evt}, 16'd1, "strobe after 3rd edge");
        tick(1);
        chk("R10", {15'd0, up_evt}, 16'd0, "strobe one cycle");
        s0 = 1'b0; tick(4);

        // R8: clear beats counting
        cur_req = "R8"; clr = 1'b1;
        s0 = 1'b1; tick(2); s0 = 1'b0; tick(4);
        clr = 1'b0; tick(1);
        chk("R8", main_count, 16'd0, "clear over edge");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule